// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

This block sits beside the program counter of a 64-bit RISC core. It recognises the control-transfer instructions, chooses the address of the next instruction and asks for a link-register write. Each cycle it takes one 32-bit instruction word, the general-register values for the rj and rd fields, and an 8-entry vector of condition flags. From these it produces the next PC, a taken flag and a link write request. The PC register lives inside the unit and advances only on a cycle whose valid strobe is high.

The covered transfers are PC-relative jumps with and without a link, a register-based jump with a link, branches that compare two registers (equal or unequal, signed or unsigned order), branches that test one register against zero, and branches that test one condition flag. Each class puts its word offset in a different set of instruction fields, so the offset is extracted only after the class is known. Any other instruction word falls through to PC+4.

Top module: `brnpc_unit`

## Requirements
- R1: After reset `cur_pc` equals the `RESET_PC` parameter (default 0x12000600). On a rising edge with `in_valid` high `cur_pc` loads `next_pc`. With `in_valid` low it keeps its value.
- R2: Bits 31:26 = 010110 branch when rj equals rd, and 010111 branch when they differ. The offset is bits 25:10, rj is bits 9:5, rd is bits 4:0.
- R3: Bits 31:26 = 011000 branch when rj is less than rd, and 011001 when rj is greater than or equal to rd. Both compare as two's-complement values.
- R4: Bits 31:26 = 011010 and 011011 make the same less-than and greater-or-equal tests as unsigned values, so rj = -2 is below rd = -1.
- R5: Bits 31:26 = 010000 branch when rj is zero, and 010001 when rj is nonzero. The 21-bit offset takes bits 15:0 from instruction bits 25:10 and bits 20:16 from instruction bits 4:0.
- R6: Bits 31:26 = 010010 test the flag selected by bits 7:5. Bits 9:8 = 00 branch if that flag is 0, and 01 branch if it is 1. The offset is split as in R5.
- R7: Bits 31:26 = 010100 (jump) and 010101 (jump with link) always take. Their 26-bit offset takes bits 15:0 from instruction bits 25:10 and bits 25:16 from instruction bits 9:0. The link form writes PC+4 to register 1.
- R8: Bits 31:26 = 010011 always take. The target is the rj value plus the sign-extended 16-bit offset (bits 25:10) times 4, and PC+4 is written to the register in bits 4:0.
- R9: A taken relative target is PC plus the sign-extended word offset times 4, and negative offsets move backward. When no branch is taken, `next_pc` is PC+4.
- R10: `link_we` is high only in a cycle with `in_valid` high and a linking instruction, and never when the destination index is 0. `link_val` is then PC+4.
- R11: An instruction word matching none of the opcodes above gives `taken` 0, no link write and `next_pc` = PC+4. This includes opcode 010010 with bits 9:8 = 10 or 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction accepted this cycle |
| instr | input | 32 | Instruction word |
| rj_val | input | 64 | Value of the register named by bits 9:5 |
| rd_val | input | 64 | Value of the register named by bits 4:0 |
| flags | input | 8 | Condition flags |
| cur_pc | output | 64 | Current PC register |
| next_pc | output | 64 | Address of the following instruction |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link destination register |
| link_val | output | 64 | Return address to write |

## Verification
The link write and the redirect happen in the same cycle for both linking jumps. The hard case is the register-based form whose rj and rd name the same register. Those scenarios drive that form with equal rj and rd fields, and also with destination 0. They confirm that the target uses the incoming rj value rather than the return address being written. They also confirm that suppressing the write to register 0 leaves the jump itself unchanged. A chain of accepted instructions without a reset between them confirms that each link value follows the PC produced by the instruction before it.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

  typedef enum logic [3:0] {
    K_SEQ, K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU,
    K_ZERO, K_NZERO, K_FLAG0, K_FLAG1, K_JUMP, K_CALL, K_RCALL
  } br_kind_e;

  // byte offsets are at most 26 word bits plus 2
  localparam int OFF_W = 28;

  function automatic logic [OFF_W-1:0] off16_bytes(input logic [31:0] w);
    return {{10{w[25]}}, w[25:10], 2'b00};
  endfunction

  function automatic logic [OFF_W-1:0] off21_bytes(input logic [31:0] w);
    return {{5{w[4]}}, w[4:0], w[25:10], 2'b00};
  endfunction

  function automatic logic [OFF_W-1:0] off26_bytes(input logic [31:0] w);
    return {w[9:0], w[25:10], 2'b00};
  endfunction

endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
  import brnpc_pkg::*;
(
  input  logic [31:0]      instr,
  output br_kind_e         kind,
  output logic [OFF_W-1:0] off_bytes,
  output logic             link_req,
  output logic [4:0]       link_dst
);

  logic [5:0] op6;
  assign op6 = instr[31:26];

  always_comb begin
    kind = K_SEQ;
    case (op6)
      6'b010110: kind = K_EQ;
      6'b010111: kind = K_NE;
      6'b011000: kind = K_LT;
      6'b011001: kind = K_GE;
      6'b011010: kind = K_LTU;
      6'b011011: kind = K_GEU;
      6'b010000: kind = K_ZERO;
      6'b010001: kind = K_NZERO;
      6'b010010: begin
        if (instr[9:8] == 2'b00)      kind = K_FLAG0;
        else if (instr[9:8] == 2'b01) kind = K_FLAG1;
        else                          kind = K_SEQ;
      end
      6'b010100: kind = K_JUMP;
      6'b010101: kind = K_CALL;
      6'b010011: kind = K_RCALL;
      default:   kind = K_SEQ;
    endcase
  end

  always_comb begin
    case (kind)
      K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU, K_RCALL:
        off_bytes = off16_bytes(instr);
      K_ZERO, K_NZERO, K_FLAG0, K_FLAG1:
        off_bytes = off21_bytes(instr);
      K_JUMP, K_CALL:
        off_bytes = off26_bytes(instr);
      default:
        off_bytes = '0;
    endcase
  end

  always_comb begin
    link_req = 1'b0;
    link_dst = 5'd0;
    if (kind == K_CALL) begin
      link_req = 1'b1;
      link_dst = 5'd1;
    end else if (kind == K_RCALL) begin
      link_req = 1'b1;
      link_dst = instr[4:0];
    end
  end

endmodule

// File: rtl/brnpc_cond.sv
module brnpc_cond
  import brnpc_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NFLAG = 8,
  localparam int FIW  = $clog2(NFLAG)
) (
  input  br_kind_e         kind,
  input  logic [XLEN-1:0]  rj_val,
  input  logic [XLEN-1:0]  rd_val,
  input  logic [NFLAG-1:0] flags,
  input  logic [FIW-1:0]   flag_idx,
  output logic             cond_ok
);

  logic eq, slt, ult, rj_zero, flag_bit;

  assign eq       = (rj_val == rd_val);
  assign slt      = ($signed(rj_val) < $signed(rd_val));
  assign ult      = (rj_val < rd_val);
  assign rj_zero  = (rj_val == '0);
  assign flag_bit = flags[flag_idx];

  always_comb begin
    case (kind)
      K_EQ:    cond_ok = eq;
      K_NE:    cond_ok = !eq;
      K_LT:    cond_ok = slt;
      K_GE:    cond_ok = !slt;
      K_LTU:   cond_ok = ult;
      K_GEU:   cond_ok = !ult;
      K_ZERO:  cond_ok = rj_zero;
      K_NZERO: cond_ok = !rj_zero;
      K_FLAG0: cond_ok = !flag_bit;
      K_FLAG1: cond_ok = flag_bit;
      K_JUMP, K_CALL, K_RCALL: cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/brnpc_target.sv
module brnpc_target
  import brnpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  br_kind_e         kind,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  rj_val,
  input  logic [OFF_W-1:0] off_bytes,
  input  logic             cond_ok,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  branch_tgt,
  output logic [XLEN-1:0]  next_pc,
  output logic             taken
);

  logic [XLEN-1:0] off_x;
  logic [XLEN-1:0] base;

  generate
    if (XLEN > OFF_W) begin : g_sext
      assign off_x = {{(XLEN-OFF_W){off_bytes[OFF_W-1]}}, off_bytes};
    end else begin : g_trunc
      assign off_x = off_bytes[XLEN-1:0];
    end
  endgenerate

  assign base       = (kind == K_RCALL) ? rj_val : pc;
  assign branch_tgt = base + off_x;
  assign seq_pc     = pc + XLEN'(4);
  assign taken      = cond_ok;
  assign next_pc    = cond_ok ? branch_tgt : seq_pc;

endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
  import brnpc_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              NFLAG    = 8,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(64'h0000_0000_1200_0600),
  localparam int             FIW      = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  rj_val,
  input  logic [XLEN-1:0]  rd_val,
  input  logic [NFLAG-1:0] flags,
  output logic [XLEN-1:0]  cur_pc,
  output logic [XLEN-1:0]  next_pc,
  output logic             taken,
  output logic             link_we,
  output logic [4:0]       link_idx,
  output logic [XLEN-1:0]  link_val
);

  br_kind_e         kind;
  logic [OFF_W-1:0] off_bytes;
  logic             link_req;
  logic [4:0]       link_dst;
  logic             cond_ok;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  branch_tgt;
  logic [XLEN-1:0]  pc_q;

  brnpc_decode u_dec (
    .instr     (instr),
    .kind      (kind),
    .off_bytes (off_bytes),
    .link_req  (link_req),
    .link_dst  (link_dst)
  );

  brnpc_cond #(.XLEN(XLEN), .NFLAG(NFLAG)) u_cond (
    .kind     (kind),
    .rj_val   (rj_val),
    .rd_val   (rd_val),
    .flags    (flags),
    .flag_idx (instr[5 +: FIW]),
    .cond_ok  (cond_ok)
  );

  brnpc_target #(.XLEN(XLEN)) u_tgt (
    .kind       (kind),
    .pc         (pc_q),
    .rj_val     (rj_val),
    .off_bytes  (off_bytes),
    .cond_ok    (cond_ok),
    .seq_pc     (seq_pc),
    .branch_tgt (branch_tgt),
    .next_pc    (next_pc),
    .taken      (taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (in_valid) pc_q <= next_pc;
  end

  assign cur_pc   = pc_q;
  assign link_idx = link_dst;
  assign link_val = seq_pc;
  assign link_we  = in_valid && link_req && (link_dst != 5'd0);

endmodule

// File: rtl/brnpc_chk.sv
module brnpc_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic            link_req,
  input logic [4:0]      link_idx,
  input logic [XLEN-1:0] link_val
);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cur_pc));

  a_r1_update: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cur_pc == $past(next_pc)));

  a_r9_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (next_pc == cur_pc + XLEN'(4)));

  a_r10_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != 5'd0));

  a_r10_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> in_valid);

  a_r10_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && link_req && link_idx == 5'd0) |-> !link_we);

  a_r10_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_val == cur_pc + XLEN'(4)));

  a_r8_link_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> taken);

endmodule

bind brnpc_unit brnpc_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .cur_pc   (cur_pc),
  .next_pc  (next_pc),
  .taken    (taken),
  .link_we  (link_we),
  .link_req (link_req),
  .link_idx (link_idx),
  .link_val (link_val)
);

// File: tb/brnpc_unit_tb.sv
module brnpc_unit_tb;

  localparam logic [63:0] PC0 = 64'h0000_0000_1200_0600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [63:0] rj_val = 64'h0;
  logic [63:0] rd_val = 64'h0;
  logic [7:0]  flags = 8'h0;
  logic [63:0] cur_pc, next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_pc;

  always #2 clk = ~clk;

  brnpc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rj_val(rj_val), .rd_val(rd_val), .flags(flags), .cur_pc(cur_pc),
    .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rel(logic [63:0] b, int words);
    longint w;
    w = words;
    return b + 64'(w * 4);
  endfunction

  function automatic logic [31:0] enc_rr(logic [5:0] op, logic [4:0] rj, logic [4:0] rd, int off);
    logic [31:0] o = 32'(off);
    return {op, o[15:0], rj, rd};
  endfunction

  function automatic logic [31:0] enc_z(logic [5:0] op, logic [4:0] rj, int off);
    logic [31:0] o = 32'(off);
    return {op, o[15:0], rj, o[20:16]};
  endfunction

  function automatic logic [31:0] enc_f(logic [1:0] sel, logic [2:0] cj, int off);
    logic [31:0] o = 32'(off);
    return {6'b010010, o[15:0], sel, cj, o[20:16]};
  endfunction

  function automatic logic [31:0] enc_j(logic [5:0] op, int off);
    logic [31:0] o = 32'(off);
    return {op, o[15:0], o[25:16]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = PC0;
  endtask

  // one accepted instruction; checks combinational outputs, then the PC update
  task automatic exec(string req, logic [31:0] iw, logic [63:0] rj, logic [63:0] rd,
                      logic [7:0] fl, logic exp_tk, logic [63:0] exp_nx,
                      logic exp_lwe, logic [4:0] exp_li);
    @(negedge clk);
    instr = iw; rj_val = rj; rd_val = rd; flags = fl; in_valid = 1'b1;
    #1;
    chk(req, "taken", 64'(taken), 64'(exp_tk));
    chk(req, "next_pc", next_pc, exp_nx);
    chk(req, "link_we", 64'(link_we), 64'(exp_lwe));
    if (exp_lwe) begin
      chk(req, "link_idx", 64'(link_idx), 64'(exp_li));
      chk(req, "link_val", link_val, exp_pc + 64'd4);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_pc = exp_nx;
    chk(req, "cur_pc after update", cur_pc, exp_pc);
  endtask

  task automatic t_reset_hold();
    do_reset();
    chk("R1", "reset pc", cur_pc, PC0);
    instr = enc_j(6'b010101, 5);
    in_valid = 1'b0;
    #1;
    chk("R10", "link_we without valid", 64'(link_we), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc held without valid", cur_pc, PC0);
  endtask

  task automatic t_equality();
    do_reset(); exec("R2 R9", enc_rr(6'b010110, 5'd12, 5'd13, -256), 64'd1, 64'd1, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R2", enc_rr(6'b010110, 5'd12, 5'd13, -256), 64'd1, 64'd0, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R2", enc_rr(6'b010111, 5'd12, 5'd13, -256), 64'd1, 64'd0, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R2", enc_rr(6'b010111, 5'd12, 5'd13, -256), 64'd1, 64'd1, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
  endtask

  task automatic t_signed();
    do_reset(); exec("R3", enc_rr(6'b011000, 5'd12, 5'd13, -256), -64'sd2, 64'd1, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R3", enc_rr(6'b011000, 5'd12, 5'd13, -256), -64'sd2, -64'sd3, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R3", enc_rr(6'b011001, 5'd12, 5'd13, -256), -64'sd2, -64'sd3, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R3", enc_rr(6'b011001, 5'd12, 5'd13, -256), -64'sd2, 64'd1, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
  endtask

  task automatic t_unsigned();
    do_reset(); exec("R4", enc_rr(6'b011010, 5'd12, 5'd13, -256), -64'sd2, -64'sd1, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R4", enc_rr(6'b011010, 5'd12, 5'd13, -256), -64'sd2, 64'd1, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R4", enc_rr(6'b011011, 5'd12, 5'd13, -256), -64'sd2, 64'd1, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R4", enc_rr(6'b011011, 5'd12, 5'd13, -256), -64'sd2, -64'sd1, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
  endtask

  task automatic t_zero();
    do_reset(); exec("R5 R9", enc_z(6'b010000, 5'd4, -256), 64'd0, 64'd7, 8'h0, 1'b1, rel(PC0, -256), 1'b0, 5'd0);
    do_reset(); exec("R5", enc_z(6'b010000, 5'd4, -256), 64'd1, 64'd0, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R5", enc_z(6'b010001, 5'd4, 32'h12345), 64'd1, 64'd0, 8'h0, 1'b1, rel(PC0, 32'h12345), 1'b0, 5'd0);
    do_reset(); exec("R5", enc_z(6'b010001, 5'd4, -70000), 64'd5, 64'd0, 8'h0, 1'b1, rel(PC0, -70000), 1'b0, 5'd0);
    do_reset(); exec("R5", enc_z(6'b010001, 5'd4, -70000), 64'd0, 64'd9, 8'h0, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
  endtask

  task automatic t_flag();
    do_reset(); exec("R6", enc_f(2'b01, 3'd5, 256), 64'd0, 64'd0, 8'h20, 1'b1, rel(PC0, 256), 1'b0, 5'd0);
    do_reset(); exec("R6", enc_f(2'b00, 3'd4, 256), 64'd0, 64'd0, 8'h20, 1'b1, rel(PC0, 256), 1'b0, 5'd0);
    do_reset(); exec("R6", enc_f(2'b00, 3'd5, 256), 64'd0, 64'd0, 8'h20, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R6", enc_f(2'b01, 3'd7, -90000), 64'd0, 64'd0, 8'h20, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    do_reset(); exec("R6", enc_f(2'b01, 3'd7, -90000), 64'd0, 64'd0, 8'h80, 1'b1, rel(PC0, -90000), 1'b0, 5'd0);
  endtask

  task automatic t_jump();
    do_reset(); exec("R7", enc_j(6'b010100, 32'h10010), 64'd0, 64'd0, 8'h0, 1'b1, rel(PC0, 32'h10010), 1'b0, 5'd0);
    do_reset(); exec("R7 R9", enc_j(6'b010100, -33554432), 64'd0, 64'd0, 8'h0, 1'b1, rel(PC0, -33554432), 1'b0, 5'd0);
    do_reset(); exec("R7", enc_j(6'b010101, 32'h10010), 64'd0, 64'd0, 8'h0, 1'b1, rel(PC0, 32'h10010), 1'b1, 5'd1);
    do_reset(); exec("R7", enc_j(6'b010101, -3), 64'd0, 64'd0, 8'h0, 1'b1, rel(PC0, -3), 1'b1, 5'd1);
  endtask

  task automatic t_rcall();
    do_reset(); exec("R8", enc_rr(6'b010011, 5'd12, 5'd1, 16), 64'h12000400, 64'd0, 8'h0, 1'b1, 64'h12000440, 1'b1, 5'd1);
    do_reset(); exec("R8", enc_rr(6'b010011, 5'd7, 5'd9, -4), 64'h8000, 64'd0, 8'h0, 1'b1, 64'h7FF0, 1'b1, 5'd9);
    // destination 0: jump still happens, write dropped
    do_reset(); exec("R10", enc_rr(6'b010011, 5'd12, 5'd0, 16), 64'h12000400, 64'd0, 8'h0, 1'b1, 64'h12000440, 1'b0, 5'd0);
    // rj and rd name the same register: target uses incoming rj value
    do_reset(); exec("R8 R10", enc_rr(6'b010011, 5'd5, 5'd5, 2), 64'h4000, 64'h4000, 8'h0, 1'b1, 64'h4008, 1'b1, 5'd5);
  endtask

  task automatic t_chain();
    logic [63:0] p1;
    do_reset();
    p1 = rel(PC0, -256);
    exec("R1", enc_rr(6'b010110, 5'd1, 5'd2, -256), 64'd3, 64'd3, 8'h0, 1'b1, p1, 1'b0, 5'd0);
    exec("R1", enc_rr(6'b010111, 5'd1, 5'd2, 40), 64'd3, 64'd3, 8'h0, 1'b0, p1 + 64'd4, 1'b0, 5'd0);
    exec("R1 R10", enc_j(6'b010101, 8), 64'd0, 64'd0, 8'h0, 1'b1, rel(p1 + 64'd4, 8), 1'b1, 5'd1);
  endtask

  task automatic t_unknown();
    do_reset(); exec("R11", 32'h0000_0000, 64'd0, 64'd0, 8'hFF, 1'b0, PC0 + 64'd4, 1'b0, 5'd0);
    exec("R11", 32'hFFFF_FFFF, 64'd0, 64'd0, 8'hFF, 1'b0, PC0 + 64'd8, 1'b0, 5'd0);
    exec("R11", enc_f(2'b10, 3'd0, 256), 64'd0, 64'd0, 8'h00, 1'b0, PC0 + 64'd12, 1'b0, 5'd0);
    exec("R11", enc_f(2'b11, 3'd1, 256), 64'd0, 64'd0, 8'hFF, 1'b0, PC0 + 64'd16, 1'b0, 5'd0);
    exec("R11", enc_rr(6'b011100, 5'd1, 5'd1, 8), 64'd0, 64'd0, 8'h0, 1'b0, PC0 + 64'd20, 1'b0, 5'd0);
  endtask

  initial begin
    t_reset_hold();
    t_equality();
    t_signed();
    t_unsigned();
    t_zero();
    t_flag();
    t_jump();
    t_rcall();
    t_chain();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule